// File: doc/BRIEF.md
# Paged Serial Flash Erase Sequencer

This block turns one erase request, given as a byte offset and a byte length, into the series of erase commands that a paged serial flash needs. The page size and the left shift that turns a page number into a device address are configuration inputs, so the same block serves both binary and non-binary page layouts. Examples are 256 bytes with shift 8, 264 with shift 9, and 528 with shift 10.

For each step the sequencer issues either an eight-page block erase or a single-page erase. It then polls the device status, with a programmable pause between polls, until the ready bit comes back. After that it advances to the next step. It drives a byte-level SPI master below it: one `spi_start` pulse per byte, one `spi_done` pulse back when the byte has been exchanged, and `spi_cs` framing each command. A request that does not align to the page size is refused without touching the bus.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose offset or length is not a whole multiple of the page size, or that arrives with a page size of zero, ends with `done` and `err` both high, and `spi_cs` stays low throughout.
- R2: A request of length zero ends with `done` high, `err` low and no bus frame.
- R3: Each erase step uses opcode 0x50 (block of eight pages) when the current page number has its three low bits zero and at least eight pages remain. Otherwise it uses opcode 0x81 (one page).
- R4: An erase frame is exactly four bytes inside one `spi_cs` high period, in this order: the opcode, bits 23:16 of A, bits 15:8 of A, and 0x00. A is the current page number shifted left by `cfg_page_shift`.
- R5: After every erase frame the block sends status frames of two bytes (0xD7 then 0x00). It repeats them while the byte received second has bit 7 clear, and moves on when that bit is set. Other status bits are ignored.
- R6: Before every status frame, `spi_cs` is low for at least `cfg_poll_gap`+1 cycles. Between any two frames it is low for at least one cycle.
- R7: A block erase advances the page number by eight and removes eight pages from the remainder. A page erase advances and removes one page. The request finishes when no pages remain.
- R8: `done` is a one-cycle pulse, `err` is high only together with `done`, and `busy` is high from acceptance until `done`. A `req_valid` pulse while busy is ignored.
- R9: `spi_start` is a one-cycle pulse issued only while `spi_cs` is high. No new byte starts until the previous one has returned `spi_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_offset | input | ADDR_W | Start byte offset |
| req_len | input | ADDR_W | Length in bytes |
| cfg_page_size | input | PS_W | Page size in bytes |
| cfg_page_shift | input | SH_W | Page number to device address shift |
| cfg_poll_gap | input | GAP_W | Idle cycles before each status poll |
| busy | output | 1 | Request in progress |
| done | output | 1 | End-of-request pulse |
| err | output | 1 | Request refused, valid with done |
| spi_cs | output | 1 | Chip select, high during a frame |
| spi_start | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received |

## Verification
The hardest situation to reach is a single request that mixes both erase sizes and a busy device. That requires a start page that is not a multiple of eight, a remainder that crosses an eight-page boundary with at least eight pages left, and a tail shorter than a block. The stimulus table picks offsets and lengths that produce page, block, page runs. The bench's device model answers a chosen number of polls per step with every status bit set except bit 7, so the retry path and the pause before each poll are exercised. A directed test pulses a misaligned request in the middle of a run to show that it is ignored.

// File: rtl/fes_pkg.sv
package fes_pkg;
   localparam logic [7:0] OP_BLK_ERASE  = 8'h50;
   localparam logic [7:0] OP_PAGE_ERASE = 8'h81;
   localparam logic [7:0] OP_STATUS     = 8'hD7;

   typedef enum logic [2:0] {
      S_IDLE, S_DIV_OFF, S_DIV_LEN, S_CMD, S_WAIT, S_POLL, S_NEXT
   } seq_state_t;
endpackage

// File: rtl/fes_divider.sv
module fes_divider #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             fin,
   output logic [NUM_W-1:0] quot,
   output logic [DEN_W-1:0] rem
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic             run;
   logic [CNT_W-1:0] cnt;
   logic [DEN_W:0]   trial;

   assign trial = {rem, quot[NUM_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         cnt  <= '0;
         quot <= '0;
         rem  <= '0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            run  <= 1'b1;
            cnt  <= '0;
            quot <= num;
            rem  <= '0;
         end else if (run) begin
            if (trial >= {1'b0, den}) begin
               rem  <= DEN_W'(trial - {1'b0, den});
               quot <= {quot[NUM_W-2:0], 1'b1};
            end else begin
               rem  <= trial[DEN_W-1:0];
               quot <= {quot[NUM_W-2:0], 1'b0};
            end
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(NUM_W - 1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fes_gap_timer.sv
module fes_gap_timer #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GAP_W-1:0] gap,
   output logic             expired
);
   logic [GAP_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= gap;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/fes_frame.sv
module fes_frame
   import fes_pkg::*;
#(
   parameter int PAGE_W   = 24,
   parameter int SH_W     = 4,
   parameter int BLK_LOG2 = 3
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [PAGE_W-1:0] left,
   input  logic [SH_W-1:0]   shift,
   input  logic              is_poll,
   input  logic [1:0]        idx,
   output logic [7:0]        tx_byte,
   output logic              is_block
);
   localparam int BLK_PAGES = 1 << BLK_LOG2;

   logic [31:0] dev_addr;

   assign dev_addr = 32'(page) << shift;
   assign is_block = (page[BLK_LOG2-1:0] == '0) && (left >= PAGE_W'(BLK_PAGES));

   always_comb begin
      if (is_poll) begin
         tx_byte = (idx == 2'd0) ? OP_STATUS : 8'h00;
      end else begin
         unique case (idx)
            2'd0:    tx_byte = is_block ? OP_BLK_ERASE : OP_PAGE_ERASE;
            2'd1:    tx_byte = dev_addr[23:16];
            2'd2:    tx_byte = dev_addr[15:8];
            default: tx_byte = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fes_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int PS_W     = 12,
   parameter int SH_W     = 4,
   parameter int GAP_W    = 8,
   parameter int BLK_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [ADDR_W-1:0] req_len,
   input  logic [PS_W-1:0]   cfg_page_size,
   input  logic [SH_W-1:0]   cfg_page_shift,
   input  logic [GAP_W-1:0]  cfg_poll_gap,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              spi_cs,
   output logic              spi_start,
   output logic [7:0]        spi_tx,
   input  logic              spi_done,
   input  logic [7:0]        spi_rx
);
   localparam int BLK_PAGES = 1 << BLK_LOG2;
   localparam logic [ADDR_W-1:0] STEP_BLK = ADDR_W'(BLK_PAGES);
   localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 8..32");
      end
      if (PS_W < 1 || PS_W > ADDR_W) begin : g_bad_ps
         $error("PS_W must lie in 1..ADDR_W");
      end
      if (BLK_LOG2 < 1 || BLK_LOG2 >= ADDR_W) begin : g_bad_blk
         $error("BLK_LOG2 out of range");
      end
   endgenerate

   seq_state_t        state;
   logic [ADDR_W-1:0] len_q, page, left;
   logic [PS_W-1:0]   ps_q;
   logic [SH_W-1:0]   sh_q;
   logic [GAP_W-1:0]  gap_q;
   logic              rem_bad, inflt;
   logic [1:0]        idx, last_idx;

   logic              div_start, div_fin;
   logic [ADDR_W-1:0] div_num, div_quot;
   logic [PS_W-1:0]   div_den, div_rem;
   logic              tmr_load, tmr_exp;
   logic [7:0]        fr_byte;
   logic              fr_block;
   logic              byte_last;

   assign div_start = (state == S_IDLE && req_valid && cfg_page_size != '0) ||
                      (state == S_DIV_OFF && div_fin);
   assign div_num   = (state == S_IDLE) ? req_offset : len_q;
   assign div_den   = (state == S_IDLE) ? cfg_page_size : ps_q;

   assign last_idx  = (state == S_POLL) ? 2'd1 : 2'd3;
   assign byte_last = inflt && spi_done && (idx == last_idx);
   assign tmr_load  = byte_last && (state == S_CMD || (state == S_POLL && !spi_rx[7]));

   fes_divider #(.NUM_W(ADDR_W), .DEN_W(PS_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
      .fin(div_fin), .quot(div_quot), .rem(div_rem)
   );

   fes_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .gap(gap_q), .expired(tmr_exp)
   );

   fes_frame #(.PAGE_W(ADDR_W), .SH_W(SH_W), .BLK_LOG2(BLK_LOG2)) u_frame (
      .page(page), .left(left), .shift(sh_q), .is_poll(state == S_POLL),
      .idx(idx), .tx_byte(fr_byte), .is_block(fr_block)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         len_q     <= '0;
         page      <= '0;
         left      <= '0;
         ps_q      <= '0;
         sh_q      <= '0;
         gap_q     <= '0;
         rem_bad   <= 1'b0;
         inflt     <= 1'b0;
         idx       <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         spi_cs    <= 1'b0;
         spi_start <= 1'b0;
         spi_tx    <= '0;
      end else begin
         spi_start <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         unique case (state)
            S_IDLE: if (req_valid) begin
               len_q <= req_len;
               ps_q  <= cfg_page_size;
               sh_q  <= cfg_page_shift;
               gap_q <= cfg_poll_gap;
               if (cfg_page_size == '0) begin
                  done <= 1'b1;
                  err  <= 1'b1;
               end else begin
                  busy  <= 1'b1;
                  state <= S_DIV_OFF;
               end
            end
            S_DIV_OFF: if (div_fin) begin
               page    <= div_quot;
               rem_bad <= (div_rem != '0);
               state   <= S_DIV_LEN;
            end
            S_DIV_LEN: if (div_fin) begin
               left  <= div_quot;
               idx   <= '0;
               inflt <= 1'b0;
               if (rem_bad || div_rem != '0 || div_quot == '0) begin
                  done  <= 1'b1;
                  err   <= rem_bad || (div_rem != '0);
                  busy  <= 1'b0;
                  state <= S_IDLE;
               end else begin
                  state <= S_CMD;
               end
            end
            S_CMD, S_POLL: begin
               spi_cs <= 1'b1;
               if (!inflt) begin
                  spi_start <= 1'b1;
                  spi_tx    <= fr_byte;
                  inflt     <= 1'b1;
               end else if (spi_done) begin
                  inflt <= 1'b0;
                  if (idx == last_idx) begin
                     spi_cs <= 1'b0;
                     idx    <= '0;
                     if (state == S_POLL && spi_rx[7]) state <= S_NEXT;
                     else                              state <= S_WAIT;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            S_WAIT: if (tmr_exp) state <= S_POLL;
            S_NEXT: begin
               page <= page + (fr_block ? STEP_BLK : STEP_ONE);
               left <= left - (fr_block ? STEP_BLK : STEP_ONE);
               if (left == (fr_block ? STEP_BLK : STEP_ONE)) begin
                  done  <= 1'b1;
                  busy  <= 1'b0;
                  state <= S_IDLE;
               end else begin
                  state <= S_CMD;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic err,
   input logic spi_cs,
   input logic spi_start,
   input logic spi_done
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend <= 1'b0;
      else if (spi_start) pend <= 1'b1;
      else if (spi_done)  pend <= 1'b0;
   end

   AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);        // R8
   AST_ERR_ONLY_END: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);          // R8
   AST_DONE_FREES:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);        // R8
   AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !spi_cs);     // R1
   AST_CS_GAP:       assert property (@(posedge clk) disable iff (!rst_n) $fell(spi_cs) |=> !spi_cs); // R6
   AST_START_FRAMED: assert property (@(posedge clk) disable iff (!rst_n) spi_start |-> spi_cs);  // R9
   AST_ONE_BYTE:     assert property (@(posedge clk) disable iff (!rst_n) spi_start |-> !pend);   // R9
   AST_START_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) spi_start |=> !spi_start); // R9
endmodule

bind flash_erase_seq fes_checker u_fes_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
   .spi_cs(spi_cs), .spi_start(spi_start), .spi_done(spi_done)
);

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;
   localparam int AW = 24, PW = 12, SW = 4, GW = 8;

   typedef struct packed {
      logic [31:0] off;
      logic [31:0] len;
      logic [31:0] ps;
      logic [31:0] sh;
      logic [31:0] gap;
      logic [31:0] bp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{32'd0,       32'd2112, 32'd264, 32'd9,  32'd2, 32'd1},
      '{32'd792,     32'd4224, 32'd264, 32'd9,  32'd0, 32'd0},
      '{32'd8448,    32'd4752, 32'd528, 32'd10, 32'd3, 32'd2},
      '{32'd256000,  32'd2048, 32'd256, 32'd8,  32'd1, 32'd3},
      '{32'd100,     32'd264,  32'd264, 32'd9,  32'd0, 32'd0},
      '{32'd264,     32'd500,  32'd264, 32'd9,  32'd0, 32'd0},
      '{32'd0,       32'd0,    32'd264, 32'd9,  32'd0, 32'd0},
      '{32'd0,       32'd264,  32'd0,   32'd9,  32'd0, 32'd0},
      '{32'd8650488, 32'd264,  32'd264, 32'd9,  32'd4, 32'd1},
      '{32'd256,     32'd2048, 32'd256, 32'd8,  32'd0, 32'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_offset = '0, req_len = '0;
   logic [PW-1:0] cfg_page_size = '0;
   logic [SW-1:0] cfg_page_shift = '0;
   logic [GW-1:0] cfg_poll_gap = '0;
   logic          busy, done, err, spi_cs, spi_start;
   logic [7:0]    spi_tx;
   logic          spi_done = 1'b0;
   logic [7:0]    spi_rx = 8'h00;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   flash_erase_seq #(.ADDR_W(AW), .PS_W(PW), .SH_W(SW), .GAP_W(GW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .req_len(req_len), .cfg_page_size(cfg_page_size), .cfg_page_shift(cfg_page_shift),
      .cfg_poll_gap(cfg_poll_gap), .busy(busy), .done(done), .err(err),
      .spi_cs(spi_cs), .spi_start(spi_start), .spi_tx(spi_tx),
      .spi_done(spi_done), .spi_rx(spi_rx)
   );

   // flash device model and bus monitor
   logic [7:0] fbuf [8];
   int   fcnt = 0, pend_cnt = 0, busy_left = 0, bp_cfg = 0, gap_cfg = 0;
   logic [7:0] ef_b [64][4];
   int   ef_len [64];
   int   n_ef = 0, n_poll = 0, bad_poll = 0, gap_bad = 0, lowcnt = 1000;
   bit   cs_prev = 1'b0;

   always @(negedge clk) begin
      spi_done = 1'b0;
      if (pend_cnt > 0) begin
         pend_cnt--;
         if (pend_cnt == 0) begin
            spi_done = 1'b1;
            if (fbuf[0] == 8'hD7 && fcnt == 2) begin
               if (busy_left > 0) begin spi_rx = 8'h7F; busy_left--; end
               else spi_rx = 8'h80;
            end else spi_rx = 8'h00;
         end
      end
      if (spi_start) begin
         if (fcnt < 8) fbuf[fcnt] = spi_tx;
         fcnt++;
         pend_cnt = 3;
      end
      if (spi_cs && !cs_prev) begin
         if (spi_tx == 8'hD7 && lowcnt < gap_cfg + 1) gap_bad++;
         lowcnt = 0;
      end
      if (!spi_cs) lowcnt++;
      if (!spi_cs && fcnt > 0) begin
         if (fbuf[0] == 8'hD7) begin
            n_poll++;
            if (fcnt != 2 || fbuf[1] != 8'h00) bad_poll++;
         end else begin
            if (n_ef < 64) begin
               for (int i = 0; i < 4; i++) ef_b[n_ef][i] = fbuf[i];
               ef_len[n_ef] = fcnt;
            end
            n_ef++;
            busy_left = bp_cfg;
         end
         fcnt = 0;
      end
      cs_prev = spi_cs;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic start_req(input vec_t v);
      @(negedge clk);
      n_ef = 0; n_poll = 0; bad_poll = 0; gap_bad = 0;
      bp_cfg = int'(v.bp); gap_cfg = int'(v.gap);
      req_offset = AW'(v.off); req_len = AW'(v.len);
      cfg_page_size = PW'(v.ps); cfg_page_shift = SW'(v.sh); cfg_poll_gap = GW'(v.gap);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output bit got_err, output bit hung);
      int c = 0;
      while (!done && c < 40000) begin @(negedge clk); c++; end
      got_err = err;
      hung = !done;
   endtask

   initial begin
      bit   e, h;
      vec_t v;
      repeat (3) @(negedge clk);
      // reset state
      chk(!busy && !done && !err && !spi_cs && !spi_start, "R8 reset outputs",
          {busy, done, err, spi_cs, spi_start}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         int page, n, cnt, mism;
         bit exp_err;
         v = VECS[k];
         exp_err = (v.ps == 0) || (v.off % v.ps != 0) || (v.len % v.ps != 0);
         start_req(v);
         wait_done(e, h);
         chk(!h, "R8 done reached", int'(h), 0);
         chk(e == exp_err, exp_err ? "R1 err flag" : "R2 err flag", int'(e), int'(exp_err));
         @(negedge clk);
         chk(!done, "R8 done one cycle", int'(done), 0);
         if (exp_err) begin
            chk(n_ef == 0 && n_poll == 0, "R1 no bus frame", n_ef + n_poll, 0);
         end else begin
            page = int'(v.off / v.ps); n = int'(v.len / v.ps); cnt = 0; mism = 0;
            while (n > 0) begin
               bit blk;
               int a;
               blk = (page % 8 == 0) && (n >= 8);
               a = (page << v.sh) & 32'hFFFFFF;
               if (cnt < n_ef && cnt < 64) begin
                  if (ef_b[cnt][0] != (blk ? 8'h50 : 8'h81)) mism++;
                  if (ef_b[cnt][1] != a[23:16] || ef_b[cnt][2] != a[15:8] ||
                      ef_b[cnt][3] != 8'h00 || ef_len[cnt] != 4) mism++;
               end
               cnt++;
               page += blk ? 8 : 1;
               n -= blk ? 8 : 1;
            end
            chk(n_ef == cnt, "R7 erase frame count", n_ef, cnt);
            chk(mism == 0, "R3 R4 erase opcode and address", mism, 0);
            chk(n_poll == cnt * (int'(v.bp) + 1), "R5 poll count", n_poll, cnt * (int'(v.bp) + 1));
            chk(bad_poll == 0, "R5 poll frame bytes", bad_poll, 0);
            chk(gap_bad == 0, "R6 poll gap", gap_bad, 0);
         end
      end

      // R8: request while busy is ignored
      v = VECS[0];
      start_req(v);
      repeat (40) @(negedge clk);
      chk(busy, "R8 busy during run", int'(busy), 1);
      req_offset = 24'd5; req_len = 24'd5; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(e, h);
      chk(!h && !e, "R8 ignored request leaves no error", int'(e | h), 0);
      @(negedge clk);
      chk(n_ef == 1 && ef_b[0][0] == 8'h50, "R8 ignored request adds no frame", n_ef, 1);
      chk(!busy, "R8 busy cleared", int'(busy), 0);

      // R9: no byte starts outside a request
      repeat (10) @(negedge clk);
      chk(!spi_start && !spi_cs, "R9 bus quiet when idle", int'(spi_cs), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule